// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Loader

This block is a hardware master that loads a configuration image into a target FPGA through that device's 8-bit slave-parallel configuration port. Image bytes arrive on a valid/ready stream. The block runs the whole sequence by itself. It pulses the program line. It waits for the target to finish clearing its memory. It holds chip select and write enable low while it writes one byte per configuration-clock pulse. It releases the two strobes in a fixed order and then keeps the clock running until the target reports that it has started up.

The configuration clock is made from the system clock. Each half-period lasts `clk_div + 1` system cycles, so software can hold the port at or below the target's maximum rate whatever the system clock is. The target's busy output can be honoured or ignored through a static input. When it is honoured, a byte the target did not take is clocked again with the same data on the bus.

Each waiting phase is bounded by a cycle budget. When the budget runs out, the block aborts, releases the strobes and sets a timeout flag. A completed load sets a success flag. The number of bytes written is counted against the length given at start.

Top module: `pcfg_loader`

## Requirements
- R1: Out of reset and while idle, the block holds `cfg_prog_n`, `cfg_cs_n`, `cfg_wr_n` and `cfg_cclk` at 1, and holds `busy`, `done_ok`, `err_timeout` and `s_ready` at 0.
- R2: A `start` pulse while idle drives `cfg_prog_n` low for exactly PROG_CYC system cycles and then releases it. A `start` seen while `busy` is 1 has no effect, so only one program pulse is produced per load.
- R3: After the program pulse, the block waits until `cfg_init_n` is 1 and `cfg_busy` is 0. If that takes more than TIMEOUT_CYC cycles, it sets `err_timeout`, returns to idle and never asserts `cfg_cs_n`.
- R4: `cfg_cs_n` and `cfg_wr_n` go low together with `cfg_cclk` high before the first byte. `cfg_cs_n` is never low while `cfg_wr_n` is high.
- R5: Each byte taken from the stream (`s_valid` and `s_ready` both 1 at a clock edge) is driven on `cfg_d`. `cfg_cclk` is then low for `clk_div+1` cycles and high for `clk_div+1` cycles. Bytes reach the target in stream order, and `cfg_d` is stable at each rising edge of `cfg_cclk`.
- R6: With `busy_chk_en` = 1, if `cfg_busy` is 1 at the end of a high phase, the block gives another full clock pulse without taking a new byte, and repeats this until `cfg_busy` is 0. The wait is bounded by TIMEOUT_CYC and ends in `err_timeout` if the budget runs out.
- R7: With `busy_chk_en` = 0, `cfg_busy` is ignored during the data phase, and exactly `xfer_len` data clock pulses are produced.
- R8: Once `byte_count` equals the latched length, `cfg_cs_n` rises first and `cfg_wr_n` rises `clk_div+1` cycles later. A length of 0 produces no data clock pulses.
- R9: After the strobes are released, `cfg_cclk` keeps pulsing with both strobes high until `cfg_done` is 1, and then `done_ok` is set. If `cfg_done` stays 0 for more than TIMEOUT_CYC cycles, the block sets `err_timeout` and stops.
- R10: `byte_count` restarts from 0 at each start and never exceeds the latched length. `done_ok` and `err_timeout` are never both 1. Both flags hold until the next accepted `start`, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (ignored while busy) |
| xfer_len | input | LEN_W | Number of image bytes, latched at start |
| busy_chk_en | input | 1 | 1: honour the target's busy output |
| clk_div | input | DIV_W | Configuration-clock half-period minus one, in system cycles |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_ready | output | 1 | Block takes the byte this cycle |
| cfg_prog_n | output | 1 | Program line to target, active low |
| cfg_cs_n | output | 1 | Chip select to target, active low |
| cfg_wr_n | output | 1 | Write enable to target, active low |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_d | output | 8 | Configuration data bus |
| cfg_init_n | input | 1 | Target initialisation status, low while clearing |
| cfg_busy | input | 1 | Target busy |
| cfg_done | input | 1 | Target startup complete |
| busy | output | 1 | A load is in progress |
| done_ok | output | 1 | Last load completed |
| err_timeout | output | 1 | Last load aborted on a timeout |
| byte_count | output | LEN_W | Bytes written in the current or last load |

## Verification
On every cycle, the assertions check how the strobes relate to each other: chip select needs write enable, and the program pulse keeps the bus idle. They also check that data is stable under each rising configuration-clock edge, that the stream is only taken inside the data phase, that write enable is released after chip select with the full count, and that each flag has a cause: success follows a seen `cfg_done`, and a timeout follows a watchdog expiry. Only the bench scenarios can show what is delivered. These are the byte order seen by a target model, the exact half-period and program-pulse widths, the extra pulses under busy stalls, the count of pulses when busy is ignored, zero-length loads, and the two timeout paths.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_INIT,
    ST_ARM,
    ST_FETCH,
    ST_LOW,
    ST_HIGH,
    ST_BLOW,
    ST_BHIGH,
    ST_REL_CS,
    ST_REL_WR,
    ST_SLOW,
    ST_SHIGH
  } pcfg_state_e;

  // Waiting classes guarded by the watchdog: 0 none, 1 init, 2 busy, 3 startup
  function automatic logic [1:0] pcfg_wait_class(input pcfg_state_e s);
    case (s)
      ST_WAIT_INIT:       return 2'd1;
      ST_BLOW, ST_BHIGH:  return 2'd2;
      ST_SLOW, ST_SHIGH:  return 2'd3;
      default:            return 2'd0;
    endcase
  endfunction

  // Level of the configuration clock in a given state
  function automatic logic pcfg_cclk_level(input pcfg_state_e s);
    return !(s == ST_LOW || s == ST_BLOW || s == ST_SLOW);
  endfunction

  function automatic logic pcfg_cs_active(input pcfg_state_e s);
    return (s == ST_ARM || s == ST_FETCH || s == ST_LOW || s == ST_HIGH ||
            s == ST_BLOW || s == ST_BHIGH);
  endfunction

  function automatic logic pcfg_wr_active(input pcfg_state_e s);
    return pcfg_cs_active(s) || (s == ST_REL_CS);
  endfunction

endpackage

// File: rtl/pcfg_phase_timer.sv
module pcfg_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] phase_cnt
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (restart)                 cnt_d = '0;
    else if (phase_cnt == '1)    cnt_d = phase_cnt;
    else                         cnt_d = phase_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_cnt <= '0;
    else        phase_cnt <= cnt_d;
  end
endmodule

// File: rtl/pcfg_wdog.sv
module pcfg_wdog #(
  parameter int LIMIT = 1000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wait_cls,
  output logic       expire
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt_q;
  logic [1:0]    cls_q;
  logic          same_cls;

  assign same_cls = (wait_cls != 2'd0) && (wait_cls == cls_q);
  assign expire   = same_cls && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cls_q <= 2'd0;
    end else begin
      cls_q <= wait_cls;
      if (!same_cls)            cnt_q <= '0;
      else if (cnt_q != '1)     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcfg_seq.sv
module pcfg_seq
  import pcfg_pkg::*;
#(
  parameter int LEN_W    = 16,
  parameter int DIV_W    = 8,
  parameter int CNT_W    = 8,
  parameter int PROG_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             busy_chk_en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic             cfg_init_n,
  input  logic             cfg_busy,
  input  logic             cfg_done,
  input  logic [CNT_W-1:0] phase_cnt,
  input  logic             tmo_evt,
  output pcfg_state_e      state_q,
  output logic             restart,
  output logic [LEN_W-1:0] len_q,
  output logic [7:0]       d_q,
  output logic             done_ok,
  output logic             err_timeout,
  output logic [LEN_W-1:0] byte_count
);
  pcfg_state_e state_d;
  logic half_done, prog_done, all_sent, take, stall, finish_ok, finish_err;

  assign half_done = (phase_cnt == CNT_W'(clk_div));
  assign prog_done = (phase_cnt == CNT_W'(PROG_CYC - 1));
  assign all_sent  = (byte_count == len_q);
  assign s_ready   = (state_q == ST_FETCH) && !all_sent;
  assign take      = s_ready && s_valid;
  assign stall     = busy_chk_en && cfg_busy;
  assign restart   = (state_d != state_q);

  always_comb begin
    state_d    = state_q;
    finish_ok  = 1'b0;
    finish_err = 1'b0;
    unique case (state_q)
      ST_IDLE:      if (start) state_d = ST_PROG;
      ST_PROG:      if (prog_done) state_d = ST_WAIT_INIT;
      ST_WAIT_INIT: begin
        if (tmo_evt) begin
          state_d = ST_IDLE; finish_err = 1'b1;
        end else if (cfg_init_n && !cfg_busy) begin
          state_d = ST_ARM;
        end
      end
      ST_ARM:       if (half_done) state_d = ST_FETCH;
      ST_FETCH: begin
        if (all_sent)  state_d = ST_REL_CS;
        else if (take) state_d = ST_LOW;
      end
      ST_LOW:       if (half_done) state_d = ST_HIGH;
      ST_HIGH:      if (half_done) state_d = stall ? ST_BLOW : ST_FETCH;
      ST_BLOW: begin
        if (tmo_evt) begin
          state_d = ST_IDLE; finish_err = 1'b1;
        end else if (half_done) state_d = ST_BHIGH;
      end
      ST_BHIGH: begin
        if (tmo_evt) begin
          state_d = ST_IDLE; finish_err = 1'b1;
        end else if (half_done) state_d = stall ? ST_BLOW : ST_FETCH;
      end
      ST_REL_CS:    if (half_done) state_d = ST_REL_WR;
      ST_REL_WR: begin
        if (half_done) begin
          if (cfg_done) begin
            state_d = ST_IDLE; finish_ok = 1'b1;
          end else state_d = ST_SLOW;
        end
      end
      ST_SLOW: begin
        if (tmo_evt) begin
          state_d = ST_IDLE; finish_err = 1'b1;
        end else if (half_done) state_d = ST_SHIGH;
      end
      ST_SHIGH: begin
        if (tmo_evt) begin
          state_d = ST_IDLE; finish_err = 1'b1;
        end else if (half_done) begin
          if (cfg_done) begin
            state_d = ST_IDLE; finish_ok = 1'b1;
          end else state_d = ST_SLOW;
        end
      end
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      len_q       <= '0;
      d_q         <= '0;
      byte_count  <= '0;
      done_ok     <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) begin
        len_q       <= xfer_len;
        byte_count  <= '0;
        done_ok     <= 1'b0;
        err_timeout <= 1'b0;
      end
      if (take) begin
        d_q        <= s_data;
        byte_count <= byte_count + 1'b1;
      end
      if (finish_ok)  done_ok     <= 1'b1;
      if (finish_err) err_timeout <= 1'b1;
    end
  end
endmodule

// File: rtl/pcfg_loader.sv
module pcfg_loader
  import pcfg_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int DIV_W       = 8,
  parameter int PROG_CYC    = 100,
  parameter int TIMEOUT_CYC = 1000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic             busy_chk_en,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [7:0]       s_data,
  input  logic             s_valid,
  output logic             s_ready,
  output logic             cfg_prog_n,
  output logic             cfg_cs_n,
  output logic             cfg_wr_n,
  output logic             cfg_cclk,
  output logic [7:0]       cfg_d,
  input  logic             cfg_init_n,
  input  logic             cfg_busy,
  input  logic             cfg_done,
  output logic             busy,
  output logic             done_ok,
  output logic             err_timeout,
  output logic [LEN_W-1:0] byte_count
);
  localparam int PW    = $clog2(PROG_CYC + 1);
  localparam int CNT_W = (DIV_W > PW) ? DIV_W : PW;

  pcfg_state_e      state_q;
  logic             restart;
  logic             tmo_evt;
  logic [CNT_W-1:0] phase_cnt;
  logic [LEN_W-1:0] len_q;
  logic [7:0]       d_q;
  logic [1:0]       wait_cls;

  assign wait_cls = pcfg_wait_class(state_q);

  pcfg_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .restart(restart), .phase_cnt(phase_cnt)
  );

  pcfg_wdog #(.LIMIT(TIMEOUT_CYC)) wdog_i (
    .clk(clk), .rst_n(rst_n), .wait_cls(wait_cls), .expire(tmo_evt)
  );

  pcfg_seq #(
    .LEN_W(LEN_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .PROG_CYC(PROG_CYC)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .busy_chk_en(busy_chk_en), .clk_div(clk_div), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .cfg_init_n(cfg_init_n),
    .cfg_busy(cfg_busy), .cfg_done(cfg_done), .phase_cnt(phase_cnt),
    .tmo_evt(tmo_evt), .state_q(state_q), .restart(restart), .len_q(len_q),
    .d_q(d_q), .done_ok(done_ok), .err_timeout(err_timeout),
    .byte_count(byte_count)
  );

  assign cfg_prog_n = (state_q != ST_PROG);
  assign cfg_cs_n   = !pcfg_cs_active(state_q);
  assign cfg_wr_n   = !pcfg_wr_active(state_q);
  assign cfg_cclk   = pcfg_cclk_level(state_q);
  assign cfg_d      = d_q;
  assign busy       = (state_q != ST_IDLE);
endmodule

module pcfg_loader_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_prog_n,
  input logic             cfg_cs_n,
  input logic             cfg_wr_n,
  input logic             cfg_cclk,
  input logic [7:0]       cfg_d,
  input logic             cfg_done,
  input logic             s_ready,
  input logic             done_ok,
  input logic             err_timeout,
  input logic [LEN_W-1:0] byte_count,
  input logic [LEN_W-1:0] len_q,
  input logic             tmo_evt
);
  assert_prog_bus_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> (cfg_cs_n && cfg_wr_n));

  assert_err_from_wdog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_timeout) |-> $past(tmo_evt));

  assert_cs_needs_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cs_n |-> !cfg_wr_n);

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_cclk) && !cfg_cs_n) |-> $stable(cfg_d));

  assert_ready_in_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (!cfg_cs_n && cfg_cclk));

  assert_wr_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_wr_n) && !err_timeout) |-> ($past(cfg_cs_n) && byte_count == len_q));

  assert_ok_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_ok) |-> $past(cfg_done));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= len_q);

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_ok && err_timeout));
endmodule

bind pcfg_loader pcfg_loader_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_prog_n(cfg_prog_n), .cfg_cs_n(cfg_cs_n),
  .cfg_wr_n(cfg_wr_n), .cfg_cclk(cfg_cclk), .cfg_d(cfg_d), .cfg_done(cfg_done),
  .s_ready(s_ready), .done_ok(done_ok), .err_timeout(err_timeout),
  .byte_count(byte_count), .len_q(len_q), .tmo_evt(tmo_evt)
);

// File: tb/pcfg_loader_tb_top.sv
module pcfg_loader_tb_top;
  localparam int LEN_W = 16;
  localparam int DIV_W = 8;
  localparam int PROG  = 5;
  localparam int TMO   = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] xfer_len = '0;
  logic busy_chk_en = 1'b0;
  logic [DIV_W-1:0] clk_div = 8'd1;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0;
  logic s_ready, cfg_prog_n, cfg_cs_n, cfg_wr_n, cfg_cclk;
  logic [7:0] cfg_d;
  logic cfg_init_n = 1'b1;
  logic cfg_busy = 1'b0;
  logic cfg_done = 1'b0;
  logic busy, done_ok, err_timeout;
  logic [LEN_W-1:0] byte_count;

  always #5 clk = ~clk;

  pcfg_loader #(.LEN_W(LEN_W), .DIV_W(DIV_W), .PROG_CYC(PROG), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .busy_chk_en(busy_chk_en), .clk_div(clk_div), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .cfg_prog_n(cfg_prog_n),
    .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n), .cfg_cclk(cfg_cclk),
    .cfg_d(cfg_d), .cfg_init_n(cfg_init_n), .cfg_busy(cfg_busy),
    .cfg_done(cfg_done), .busy(busy), .done_ok(done_ok),
    .err_timeout(err_timeout), .byte_count(byte_count)
  );

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  // target model settings
  int  init_delay = 10;
  int  done_after = 3;
  int  stall_at = -1;
  int  stall_left = 0;
  bit  busy_stuck = 1'b0;

  // observations
  logic [7:0] cap [32];
  logic [7:0] tx [32];
  int ncap, nedge, nstart, mid_edges, prog_run, prog_w, prog_falls;
  int low_run, low_w, cs_rise_t, wr_rise_t, init_cnt;
  bit cs_seen;
  logic p_cclk = 1'b1, p_cs = 1'b1, p_wr = 1'b1, p_prog = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    ncap = 0; nedge = 0; nstart = 0; mid_edges = 0; prog_run = 0; prog_w = 0;
    prog_falls = 0; low_run = 0; low_w = 0; cs_rise_t = 0; wr_rise_t = 0;
    cs_seen = 1'b0;
  endtask

  // target model and monitor, sampled away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (!cfg_prog_n) begin
        cfg_init_n <= 1'b0; cfg_done <= 1'b0; cfg_busy <= 1'b0; init_cnt = 0;
        prog_run++;
      end else if (!cfg_init_n) begin
        init_cnt++;
        if (init_delay >= 0 && init_cnt >= init_delay) cfg_init_n <= 1'b1;
      end
      if (p_prog && !cfg_prog_n) prog_falls++;
      if (!p_prog && cfg_prog_n) prog_w = prog_run;
      if (!cfg_cs_n) cs_seen = 1'b1;
      if (cfg_cs_n && !p_cs) cs_rise_t = cyc;
      if (cfg_wr_n && !p_wr) wr_rise_t = cyc;
      if (!cfg_cclk && !cfg_cs_n) low_run++;
      if (cfg_cclk && !p_cclk) begin
        if (!cfg_cs_n && !cfg_wr_n) begin
          nedge++;
          low_w = low_run; low_run = 0;
          if (ncap == stall_at && stall_left > 0) begin
            stall_left--; cfg_busy <= 1'b1;
          end else begin
            cap[ncap] = cfg_d; ncap++; cfg_busy <= busy_stuck;
          end
        end else if (cfg_cs_n && cfg_wr_n && busy) begin
          nstart++;
          if (done_after >= 0 && nstart >= done_after) cfg_done <= 1'b1;
        end else begin
          mid_edges++;
        end
      end
    end
    p_cclk = cfg_cclk; p_cs = cfg_cs_n; p_wr = cfg_wr_n; p_prog = cfg_prog_n;
  end

  task automatic fill(input int n, input int seed);
    for (int i = 0; i < n; i++) tx[i] = 8'(seed + i * 37) ^ 8'hA5;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (busy && k < 20000) begin
      @(negedge clk); k++;
    end
    chk(!busy, "R9", "load did not end", 32'(busy), 0);
  endtask

  task automatic run_load(input int n, input int div, input bit en,
                          input int gap, input bit restart_mid);
    clear_mon();
    clk_div = 8'(div); busy_chk_en = en; xfer_len = 16'(n);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
      s_valid = 1'b1; s_data = tx[i];
      while (!s_ready && busy) @(negedge clk);
      if (!busy) break;
      @(negedge clk);
      if (restart_mid && i == 0) start = 1'b1;
      else start = 1'b0;
    end
    s_valid = 1'b0; start = 1'b0;
    wait_idle();
    @(negedge clk);
  endtask

  task automatic check_bytes(input int n, input string req);
    chk(ncap == n, req, "captured byte count", ncap, n);
    for (int i = 0; i < n && i < ncap; i++)
      chk(cap[i] == tx[i], req, "byte order/value", int'(cap[i]), int'(tx[i]));
  endtask

  task automatic t_reset();
    chk(cfg_prog_n && cfg_cs_n && cfg_wr_n && cfg_cclk, "R1", "idle strobes",
        int'({cfg_prog_n, cfg_cs_n, cfg_wr_n, cfg_cclk}), 15);
    chk(!busy && !done_ok && !err_timeout && !s_ready, "R1", "idle status",
        int'({busy, done_ok, err_timeout, s_ready}), 0);
  endtask

  task automatic t_basic();
    fill(6, 3); done_after = 3;
    run_load(6, 1, 1'b1, 2, 1'b1);
    check_bytes(6, "R5");
    chk(prog_w == PROG, "R2", "program pulse width", prog_w, PROG);
    chk(prog_falls == 1, "R2", "start while busy ignored", prog_falls, 1);
    chk(low_w == 2, "R5", "low half-period", low_w, 2);
    chk(wr_rise_t - cs_rise_t == 2, "R8", "cs then wr release gap",
        wr_rise_t - cs_rise_t, 2);
    chk(mid_edges == 0, "R8", "edges between releases", mid_edges, 0);
    chk(nstart == 3, "R9", "startup pulses", nstart, 3);
    chk(done_ok && !err_timeout, "R9", "done_ok set", int'({done_ok, err_timeout}), 2);
    chk(byte_count == 6, "R10", "byte count", int'(byte_count), 6);
  endtask

  task automatic t_div3();
    fill(3, 90);
    run_load(3, 3, 1'b0, 0, 1'b0);
    check_bytes(3, "R5");
    chk(low_w == 4, "R5", "low half-period div3", low_w, 4);
    chk(nedge == 3, "R5", "data edges", nedge, 3);
  endtask

  task automatic t_busy_stall();
    fill(5, 17); stall_at = 2; stall_left = 3;
    run_load(5, 1, 1'b1, 0, 1'b0);
    check_bytes(5, "R6");
    chk(nedge == 8, "R6", "data edges incl. repeats", nedge, 8);
    chk(done_ok, "R6", "done after stall", int'(done_ok), 1);
    stall_at = -1; stall_left = 0;
  endtask

  task automatic t_busy_ignored();
    fill(4, 200); busy_stuck = 1'b1;
    run_load(4, 1, 1'b0, 1, 1'b0);
    chk(nedge == 4, "R7", "edges with busy ignored", nedge, 4);
    chk(done_ok, "R7", "done with busy ignored", int'(done_ok), 1);
    busy_stuck = 1'b0;
  endtask

  task automatic t_zero_len();
    run_load(0, 1, 1'b1, 0, 1'b0);
    chk(nedge == 0, "R8", "zero length data edges", nedge, 0);
    chk(done_ok && byte_count == 0, "R8", "zero length done/count",
        int'(byte_count), 0);
  endtask

  task automatic t_init_tmo();
    fill(2, 5); init_delay = -1;
    run_load(2, 1, 1'b1, 0, 1'b0);
    chk(err_timeout && !done_ok, "R3", "init timeout flags",
        int'({done_ok, err_timeout}), 1);
    chk(!cs_seen, "R3", "chip select never asserted", int'(cs_seen), 0);
    init_delay = 10;
  endtask

  task automatic t_done_tmo();
    fill(2, 66); done_after = -1;
    run_load(2, 0, 1'b1, 0, 1'b0);
    check_bytes(2, "R9");
    chk(err_timeout && !done_ok, "R9", "done timeout flags",
        int'({done_ok, err_timeout}), 1);
    chk(cfg_cs_n && cfg_wr_n, "R9", "strobes released after abort",
        int'({cfg_cs_n, cfg_wr_n}), 3);
    done_after = 3;
  endtask

  task automatic t_flags_clear();
    fill(1, 11);
    run_load(1, 0, 1'b1, 0, 1'b0);
    chk(!err_timeout && done_ok, "R10", "flags cleared at new start",
        int'({done_ok, err_timeout}), 2);
    check_bytes(1, "R5");
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_div3();
    t_busy_stall();
    t_busy_ignored();
    t_zero_len();
    t_init_tmo();
    t_done_tmo();
    t_flags_clear();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule